// File: doc/BRIEF.md
# M/N I2C bit-rate generator

This block derives the serial clock timing of an I2C master from a fast system clock. An 8-bit divider setting splits into a linear factor M and an exponent N. The system clock is first divided by a power of two set by N, and then by M+1. The result is a sample tick at ten times the SCL rate. A fixed ten-tick sequencer turns these ticks into two phase indicators: the low half and the high half of each SCL period. The bus state machine uses them to place its edges.

The bus controller raises a run request while it drives a bus action. While the request is low, every counter is held at zero. A new action therefore always begins at the start of a low half. A new divider setting is adopted only while the generator is idle or exactly at the end of an SCL period, so a period in progress never changes length. The power-of-two stage is chosen at elaboration time: either 2^(N+1) (the default) or 2^N.

Top module: `mn_bitrate_gen`

## Requirements
- R1: The setting input carries M in bits 7..4 and N in bits 3..0. Distinct M and N give a tick period of (M+1) times the prescale length.
- R2: After reset, the active setting is 0x44 (M=4, N=4) and all outputs are low. If the run request is already high on the first edge after reset, the first period uses 0x44.
- R3: In the default variant (POW_VARIANT=0), with the run request high, tick_o is high for one cycle every 2^(N+1)·(M+1) system clock cycles.
- R4: In the alternate variant (POW_VARIANT=1), the tick period is 2^N·(M+1) cycles. With N=0 and M=0, the tick is high on every cycle.
- R5: One SCL period is 10 ticks. scl_low_o is high during the first 5 ticks and scl_high_o during the last 5. While running, exactly one of the two is high.
- R6: While run_i is low, tick_o, scl_low_o and scl_high_o are low and the counters are zero. When run_i rises, scl_low_o is high at once, and the first tick comes one full tick period after the rise.
- R7: A setting change while running is adopted only on the clock edge that ends a 10-tick period. While run_i is low, the setting is adopted on every edge.
- R8: N values 8..15 act as N=7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| baud_i | input | 8 | Divider setting: M in bits 7..4, N in bits 3..0 |
| run_i | input | 1 | Run request from the bus state machine; low holds the counters at zero |
| tick_o | output | 1 | Sample tick at ten times the SCL rate |
| scl_low_o | output | 1 | High during the low half of the SCL period |
| scl_high_o | output | 1 | High during the high half of the SCL period |

## Verification
The assertions assume that run_i and baud_i change only between clock edges, and that run_i is low while reset is applied. The stimulus drives both inputs on the falling edge and keeps run_i low during reset. The bounded-count checks also assume that the active setting changes only together with a counter restart. The stimulus tests this by changing baud_i in the middle of a period and by dropping run_i mid-period, and it uses both ends of the M and N ranges, including N values above 7.

// File: rtl/mn_pkg.sv
package mn_pkg;
  localparam int BAUD_W = 8;
  localparam int M_W = 4;
  localparam int N_W = 4;
  localparam int N_MAX = 7;
  localparam int TICKS_PER_SCL = 10;
  localparam logic [BAUD_W-1:0] RESET_BAUD = 8'h44;

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [N_W-1:0] n;
  } baud_t;
endpackage

// File: rtl/mn_prescaler.sv
module mn_prescaler #(
  parameter int N_W = 4,
  parameter int N_MAX = 7,
  parameter bit POW_VARIANT = 1'b0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [N_W-1:0] n_i,
  output logic           stb_o
);
  localparam int CNT_W = N_MAX + 1;

  logic [N_W-1:0] n_sat;
  logic [N_W:0]   shift;
  logic [CNT_W-1:0] term, cnt;

  assign n_sat = (n_i > N_W'(N_MAX)) ? N_W'(N_MAX) : n_i;

  generate
    if (POW_VARIANT) begin : g_pow_n
      assign shift = {1'b0, n_sat};
    end else begin : g_pow_n1
      assign shift = {1'b0, n_sat} + (N_W+1)'(1);
    end
  endgenerate

  // terminal count = 2^shift - 1
  always_comb begin
    for (int i = 0; i < CNT_W; i++) term[i] = (i < int'(shift));
  end

  assign stb_o = run_i && (cnt == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt <= '0;
    else if (!run_i) cnt <= '0;
    else if (stb_o)  cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R3
  pre_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt <= term));
endmodule

// File: rtl/mn_lin_div.sv
module mn_lin_div #(
  parameter int M_W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           stb_i,
  input  logic [M_W-1:0] m_i,
  output logic           tick_o
);
  logic [M_W-1:0] cnt;

  assign tick_o = stb_i && (cnt == m_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt <= '0;
    else if (!run_i) cnt <= '0;
    else if (stb_i)  cnt <= (cnt == m_i) ? '0 : cnt + 1'b1;
  end

  // R3
  lin_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt <= m_i));
endmodule

// File: rtl/mn_phase_seq.sv
module mn_phase_seq #(
  parameter int TICKS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic scl_low_o,
  output logic scl_high_o,
  output logic period_end_o
);
  localparam int PH_W = $clog2(TICKS);
  localparam int HALF = TICKS / 2;
  localparam logic [PH_W-1:0] LAST = PH_W'(TICKS - 1);

  logic [PH_W-1:0] ph;

  assign period_end_o = tick_i && (ph == LAST);
  assign scl_low_o    = run_i && (ph <  PH_W'(HALF));
  assign scl_high_o   = run_i && (ph >= PH_W'(HALF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ph <= '0;
    else if (!run_i)       ph <= '0;
    else if (period_end_o) ph <= '0;
    else if (tick_i)       ph <= ph + 1'b1;
  end

  // R5
  ph_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph <= LAST);
  // R5
  ph_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(ph));
  // R6
  ph_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (ph == '0));
endmodule

// File: rtl/mn_bitrate_gen.sv
module mn_bitrate_gen
  import mn_pkg::*;
#(
  parameter bit POW_VARIANT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic              run_i,
  output logic              tick_o,
  output logic              scl_low_o,
  output logic              scl_high_o
);
  baud_t cfg;
  logic  pre_stb, period_end;

  // setting is only swapped while idle or at a period edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cfg <= baud_t'(RESET_BAUD);
    else if (!run_i || period_end) cfg <= baud_t'(baud_i);
  end

  mn_prescaler #(
    .N_W(N_W), .N_MAX(N_MAX), .POW_VARIANT(POW_VARIANT)
  ) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i),
    .n_i(cfg.n), .stb_o(pre_stb)
  );

  mn_lin_div #(.M_W(M_W)) u_lin (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i),
    .stb_i(pre_stb), .m_i(cfg.m), .tick_o(tick_o)
  );

  mn_phase_seq #(.TICKS(TICKS_PER_SCL)) u_ph (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .tick_i(tick_o),
    .scl_low_o(scl_low_o), .scl_high_o(scl_high_o),
    .period_end_o(period_end)
  );

  // R7
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !period_end) |=> $stable(cfg));
  // R6
  run_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> (scl_low_o && !scl_high_o));
  // R3
  tick_needs_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> pre_stb);
endmodule

// File: tb/sim_mn_bitrate_gen.sv
module sim_mn_bitrate_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] baud_i = 8'h00;
  logic       run_i = 1'b0;
  logic       t0, l0, h0, t1, l1, h1;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [5:0] exp_q[$];
  string      tag_q[$];

  // model state: default (0) and alternate (1) variants
  int s0 = 0, s1 = 0;
  logic [7:0] c0 = 8'h44, c1 = 8'h44;

  always #4 clk_i = ~clk_i;

  mn_bitrate_gen #(.POW_VARIANT(1'b0)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .baud_i(baud_i), .run_i(run_i),
    .tick_o(t0), .scl_low_o(l0), .scl_high_o(h0)
  );
  mn_bitrate_gen #(.POW_VARIANT(1'b1)) u1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .baud_i(baud_i), .run_i(run_i),
    .tick_o(t1), .scl_low_o(l1), .scl_high_o(h1)
  );

  function automatic int dlen(logic [7:0] c, bit alt);
    int n = (c[3:0] > 4'd7) ? 7 : int'(c[3:0]);
    int m = int'(c[7:4]);
    return alt ? (1 << n) * (m + 1) : (2 << n) * (m + 1);
  endfunction

  function automatic logic [2:0] ex(bit run, int s, int d);
    int ph;
    if (!run) return 3'b000;
    ph = s / d;
    return {((s % d) == d - 1), (ph < 5), (ph >= 5)};
  endfunction

  task automatic step(bit rst, bit run, logic [7:0] b, string tag);
    int d0, d1;
    rst_ni = rst; run_i = run; baud_i = b;
    d0 = dlen(c0, 1'b0);
    d1 = dlen(c1, 1'b1);
    exp_q.push_back({ex(run, s0, d0), ex(run, s1, d1)});
    tag_q.push_back(tag);
    @(posedge clk_i);
    if (!rst) begin s0 = 0; c0 = 8'h44; s1 = 0; c1 = 8'h44; end
    else if (!run) begin s0 = 0; c0 = b; s1 = 0; c1 = b; end
    else begin
      s0++; if (s0 == 10 * d0) begin s0 = 0; c0 = b; end
      s1++; if (s1 == 10 * d1) begin s1 = 0; c1 = b; end
    end
    @(negedge clk_i);
  endtask

  task automatic burst(bit run, logic [7:0] b, int n, string tag);
    for (int i = 0; i < n; i++) step(1'b1, run, b, tag);
  endtask

  // monitor
  always @(negedge clk_i) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [5:0] e;
      string tg;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      vectors++;
      if ({t0, l0, h0, t1, l1, h1} !== e) begin
        fails++;
        $display("FAIL %s: got %b expected %b at %0t", tg,
                 {t0, l0, h0, t1, l1, h1}, e, $time);
      end
    end
  end

  initial begin
    @(negedge clk_i);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 8'h00, "R2");
    // R2: leave reset already running; 0x44 must apply, then R7 switch to 0x00
    burst(1'b1, 8'h00, 1700, "R2");
    burst(1'b0, 8'h12, 3, "R6");
    // R3: M=1 N=2
    burst(1'b1, 8'h12, 400, "R3");
    // R7: mid-period change to M=2 N=3
    burst(1'b1, 8'h23, 700, "R7");
    burst(1'b0, 8'h0F, 2, "R6");
    // R8: N=15 saturates to 7
    burst(1'b1, 8'h0F, 3000, "R8");
    burst(1'b0, 8'hF0, 1, "R6");
    // R4: M=15 N=0
    burst(1'b1, 8'hF0, 500, "R4");
    burst(1'b0, 8'h00, 1, "R4");
    // R4: D=1 case in the alternate variant
    burst(1'b1, 8'h00, 30, "R4");
    burst(1'b0, 8'h52, 1, "R1");
    // R1: M=5 N=2
    burst(1'b1, 8'h52, 600, "R1");
    burst(1'b0, 8'h10, 2, "R5");
    // R5: full periods at M=1 N=0
    burst(1'b1, 8'h10, 100, "R5");
    // R6: drop mid-period and restart from the low half
    burst(1'b0, 8'h10, 1, "R6");
    burst(1'b1, 8'h10, 50, "R6");
    burst(1'b0, 8'h10, 2, "R6");
    @(negedge clk_i);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule